// File: doc/BRIEF.md
# Fusible Bit-Sliced Multiply-Accumulate Array

This block holds sixteen small multipliers, each taking a 2-bit weight slice and a 2-bit activation slice. A run-time width select regroups them. At 2 bits, each unit is its own multiply-accumulate lane, which gives sixteen lanes. At 4 bits, four units are joined into one lane, which gives four lanes. At 8 bits, all sixteen units form a single lane. Inside a joined lane, each unit's partial product is shifted left by twice the sum of its weight-slice index and activation-slice index, and the lane sums these shifted terms. The chosen width applies to both operands.

Each cycle a caller presents a packed weight vector, a packed activation vector, a signedness flag, the width select, and a start flag. Each lane keeps a 20-bit running sum. The first stage registers the sixteen slice products. The second stage forms the lane sums and updates the accumulators. When the width select changes, all accumulators are cleared, so the caller should change the width only between accumulation runs.

Top module: `bd_fused_mac`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and all sixteen 20-bit fields of `acc_flat` are 0.
- R2: With `mode` = 2'b00, lane k (k = 0..15) multiplies weight bits [2k+1:2k] by activation bits [2k+1:2k] and accumulates the product into field k, which is `acc_flat[20k+19:20k]`.
- R3: With `mode` = 2'b01, lane k (k = 0..3) multiplies weight bits [4k+3:4k] by activation bits [4k+3:4k] into field k. Fields 4..15 stay 0.
- R4: With `mode` = 2'b10, weight bits [7:0] are multiplied by activation bits [7:0] into field 0, and fields 1..15 stay 0. `mode` = 2'b11 behaves exactly like 2'b10.
- R5: With `is_signed` = 1, both operand elements are two's complement at the selected width. With `is_signed` = 0, both are unsigned.
- R6: An input accepted with `in_valid` at one rising edge changes `acc_flat` and raises `out_valid` on the second rising edge after it. `out_valid` is high only for inputs that were valid.
- R7: A valid input with `acc_start` = 1 loads each field with its new product. A valid input with `acc_start` = 0 adds the product to the field's current value.
- R8: When the effective width differs from that of the previous cycle, every field is cleared. If that input is valid, each field is instead loaded with its new product, whatever `acc_start` is.
- R9: Each field wraps modulo 2^20.
- R10: Operand bits above the elements that the selected width uses have no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| acc_start | input | 1 | Load instead of add for this input |
| is_signed | input | 1 | Operands are two's complement |
| mode | input | 2 | Width select: 00 = 2-bit, 01 = 4-bit, 10 or 11 = 8-bit |
| w_vec | input | 32 | Packed weight elements |
| a_vec | input | 32 | Packed activation elements |
| out_valid | output | 1 | Accumulators were updated by a valid input |
| acc_flat | output | 320 | Sixteen 20-bit lane accumulators, lane k at bits [20k+19:20k] |

## Verification
The bench targets the following corner cases. Each is listed with the wrong result that a faulty design would produce:
- Signed products of the most negative values: -2 x -2 at 2 bits and -128 x -128 at 8 bits. Treating a lower slice as signed, or failing to extend the top slice's sign, gives a wrong magnitude or a wrong sign.
- A run of seventeen 255 x 255 products. This must wrap past 2^20; a design that saturates, or that drops the top shifted term, gives the wrong wrapped value.
- Width changes with the input idle and with the input valid. If the clear is missing, values from the previous width stay in the fields.
- Mode 2'b11, and junk in the unused high operand bits. A wrong width decode or a leaky slice router makes extra lanes nonzero.

// File: rtl/bd_mac_pkg.sv
package bd_mac_pkg;

  localparam int SLICE_W   = 2;
  localparam int MAX_W     = 8;
  localparam int SIDE_MAX  = MAX_W / SLICE_W;
  localparam int NUM_UNITS = SIDE_MAX * SIDE_MAX;
  localparam int VEC_W     = SLICE_W * NUM_UNITS;
  localparam int PROD_W    = 2 * (SLICE_W + 1);

  typedef enum logic [1:0] {
    BD_W2 = 2'd0,
    BD_W4 = 2'd1,
    BD_W8 = 2'd2
  } bd_width_e;

  function automatic bd_width_e norm_mode(input logic [1:0] raw);
    return (raw == 2'b11) ? BD_W8 : bd_width_e'(raw);
  endfunction

  // slices per operand in one lane: 1, 2 or 4
  function automatic int side_of(input bd_width_e m);
    return 1 << int'(m);
  endfunction

  function automatic int unit_group(input int u, input bd_width_e m);
    int s;
    s = side_of(m);
    return u / (s * s);
  endfunction

  function automatic int unit_row(input int u, input bd_width_e m);
    int s;
    s = side_of(m);
    return (u % (s * s)) / s;
  endfunction

  function automatic int unit_col(input int u, input bd_width_e m);
    int s;
    s = side_of(m);
    return (u % (s * s)) % s;
  endfunction

  function automatic int unit_shift(input int u, input bd_width_e m);
    return SLICE_W * (unit_row(u, m) + unit_col(u, m));
  endfunction

endpackage

// File: rtl/bd_slice_router.sv
module bd_slice_router
  import bd_mac_pkg::*;
#(
  parameter int SW = SLICE_W,
  parameter int NU = NUM_UNITS,
  localparam int VW = SW * NU
) (
  input  bd_width_e     mode,
  input  logic          sgn,
  input  logic [VW-1:0] w_vec,
  input  logic [VW-1:0] a_vec,
  output logic [SW-1:0] w_sl  [NU],
  output logic [SW-1:0] a_sl  [NU],
  output logic          w_sgn [NU],
  output logic          a_sgn [NU]
);

  for (genvar u = 0; u < NU; u++) begin : g_unit
    always_comb begin
      int side;
      int base;
      int ri;
      int cj;
      side = side_of(mode);
      ri   = unit_row(u, mode);
      cj   = unit_col(u, mode);
      base = unit_group(u, mode) * side * SW;
      w_sl[u]  = w_vec[base + ri * SW +: SW];
      a_sl[u]  = a_vec[base + cj * SW +: SW];
      // only the top slice of an element carries the sign
      w_sgn[u] = sgn && (ri == side - 1);
      a_sgn[u] = sgn && (cj == side - 1);
    end
  end

endmodule

// File: rtl/bd_slice_mul.sv
module bd_slice_mul #(
  parameter int SW = 2,
  localparam int PW = 2 * (SW + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SW-1:0]        w_sl,
  input  logic [SW-1:0]        a_sl,
  input  logic                 w_sgn,
  input  logic                 a_sgn,
  output logic signed [PW-1:0] prod
);

  logic signed [SW:0]   w_ext;
  logic signed [SW:0]   a_ext;
  logic signed [PW-1:0] prod_d;

  assign w_ext  = {w_sgn & w_sl[SW-1], w_sl};
  assign a_ext  = {a_sgn & a_sl[SW-1], a_sl};
  assign prod_d = w_ext * a_ext;

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= prod_d;
  end

  // R5: two unsigned slices never give a negative partial product
  p_unsigned_nonneg_r5: assert property (@(posedge clk) disable iff (rst)
    (!w_sgn && !a_sgn) |=> !prod[PW-1]);

endmodule

// File: rtl/bd_fuse_tree.sv
module bd_fuse_tree
  import bd_mac_pkg::*;
#(
  parameter int SW    = SLICE_W,
  parameter int NU    = NUM_UNITS,
  parameter int ACC_W = 20,
  localparam int PW   = 2 * (SW + 1)
) (
  input  bd_width_e                mode,
  input  logic signed [PW-1:0]     prod    [NU],
  output logic signed [ACC_W-1:0]  grp_sum [NU]
);

  for (genvar g = 0; g < NU; g++) begin : g_lane
    always_comb begin
      logic signed [ACC_W-1:0] sum;
      logic signed [ACC_W-1:0] term;
      sum = '0;
      for (int u = 0; u < NU; u++) begin
        term = {{(ACC_W-PW){prod[u][PW-1]}}, prod[u]};
        if (unit_group(u, mode) == g)
          sum = sum + (term <<< unit_shift(u, mode));
      end
      grp_sum[g] = sum;
    end
  end

endmodule

// File: rtl/bd_group_acc.sv
module bd_group_acc
  import bd_mac_pkg::*;
#(
  parameter int NU    = NUM_UNITS,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s1_valid,
  input  logic                    s1_start,
  input  bd_width_e               s1_mode,
  input  logic signed [ACC_W-1:0] grp_sum [NU],
  output logic        [ACC_W-1:0] acc     [NU],
  output logic                    out_valid
);

  bd_width_e acc_mode;
  logic      mode_chg;
  logic      acc_nz;

  assign mode_chg = (s1_mode != acc_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_mode  <= BD_W2;
      out_valid <= 1'b0;
      for (int g = 0; g < NU; g++) acc[g] <= '0;
    end else begin
      acc_mode  <= s1_mode;
      out_valid <= s1_valid;
      for (int g = 0; g < NU; g++) begin
        if (s1_valid) begin
          if (s1_start || mode_chg) acc[g] <= grp_sum[g];
          else                      acc[g] <= acc[g] + grp_sum[g];
        end else if (mode_chg) begin
          acc[g] <= '0;
        end
      end
    end
  end

  always_comb begin
    acc_nz = 1'b0;
    for (int g = 0; g < NU; g++) acc_nz = acc_nz | (|acc[g]);
  end

  // R8: an idle cycle with a width change leaves every lane at zero
  p_mode_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_chg && !s1_valid) |=> !acc_nz);

  for (genvar g = 1; g < NU; g++) begin : g_chk
    if (g >= 4) begin : g_w4
      // R3: lanes beyond the fourth carry nothing at 4 or 8 bits
      p_idle_groups_r3: assert property (@(posedge clk) disable iff (rst)
        (s1_mode != BD_W2) |-> (grp_sum[g] == '0));
    end
    // R4: only lane 0 is fed at 8 bits
    p_single_group_r4: assert property (@(posedge clk) disable iff (rst)
      (s1_mode == BD_W8) |-> (grp_sum[g] == '0));
  end

endmodule

// File: rtl/bd_fused_mac.sv
module bd_fused_mac
  import bd_mac_pkg::*;
#(
  parameter int ACC_W = 20,
  localparam int NU   = NUM_UNITS,
  localparam int SW   = SLICE_W,
  localparam int VW   = VEC_W,
  localparam int PW   = PROD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               acc_start,
  input  logic               is_signed,
  input  logic [1:0]         mode,
  input  logic [VW-1:0]      w_vec,
  input  logic [VW-1:0]      a_vec,
  output logic               out_valid,
  output logic [NU*ACC_W-1:0] acc_flat
);

  bd_width_e mode_n;
  assign mode_n = norm_mode(mode);

  logic [SW-1:0]           w_sl  [NU];
  logic [SW-1:0]           a_sl  [NU];
  logic                    w_sgn [NU];
  logic                    a_sgn [NU];
  logic signed [PW-1:0]    prod  [NU];
  logic signed [ACC_W-1:0] grp_sum [NU];
  logic [ACC_W-1:0]        acc   [NU];

  logic      s1_valid;
  logic      s1_start;
  bd_width_e s1_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_start <= 1'b0;
      s1_mode  <= BD_W2;
    end else begin
      s1_valid <= in_valid;
      s1_start <= acc_start;
      s1_mode  <= mode_n;
    end
  end

  bd_slice_router #(.SW(SW), .NU(NU)) u_router (
    .mode  (mode_n),
    .sgn   (is_signed),
    .w_vec (w_vec),
    .a_vec (a_vec),
    .w_sl  (w_sl),
    .a_sl  (a_sl),
    .w_sgn (w_sgn),
    .a_sgn (a_sgn)
  );

  for (genvar u = 0; u < NU; u++) begin : g_mul
    bd_slice_mul #(.SW(SW)) u_mul (
      .clk   (clk),
      .rst   (rst),
      .w_sl  (w_sl[u]),
      .a_sl  (a_sl[u]),
      .w_sgn (w_sgn[u]),
      .a_sgn (a_sgn[u]),
      .prod  (prod[u])
    );
  end

  bd_fuse_tree #(.SW(SW), .NU(NU), .ACC_W(ACC_W)) u_tree (
    .mode    (s1_mode),
    .prod    (prod),
    .grp_sum (grp_sum)
  );

  bd_group_acc #(.NU(NU), .ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1_start  (s1_start),
    .s1_mode   (s1_mode),
    .grp_sum   (grp_sum),
    .acc       (acc),
    .out_valid (out_valid)
  );

  for (genvar g = 0; g < NU; g++) begin : g_out
    assign acc_flat[g*ACC_W +: ACC_W] = acc[g];
  end

  // R6: a result appears only two edges after a valid input
  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

endmodule

// File: tb/tb_bd_fused_mac.sv
module tb_bd_fused_mac;

  localparam int NU = 16;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, acc_start, is_signed;
  logic [1:0] mode;
  logic [31:0] w_vec, a_vec;
  logic out_valid;
  logic [NU*AW-1:0] acc_flat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bd_fused_mac dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_start(acc_start),
    .is_signed(is_signed), .mode(mode), .w_vec(w_vec), .a_vec(a_vec),
    .out_valid(out_valid), .acc_flat(acc_flat)
  );

  // bench model state
  logic [AW-1:0]    macc [NU];
  int               prev_side = 1;
  logic             ev1 = 0, ev2 = 0;
  logic [NU*AW-1:0] ea1 = '0, ea2 = '0;
  string            tg1 = "R1", tg2 = "R1";

  function automatic int side_for(input logic [1:0] md);
    return (md == 2'b00) ? 1 : (md == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [AW-1:0] lane_prod(input int g, input int side,
      input logic sg, input logic [31:0] w, input logic [31:0] a);
    int wd, wv, av;
    wd = 2 * side;
    if (g >= NU / (side * side)) return '0;
    wv = int'((w >> (wd * g)) & ((32'd1 << wd) - 1));
    av = int'((a >> (wd * g)) & ((32'd1 << wd) - 1));
    if (sg && wv >= (1 << (wd - 1))) wv = wv - (1 << wd);
    if (sg && av >= (1 << (wd - 1))) av = av - (1 << wd);
    return AW'(wv * av);
  endfunction

  task automatic step(input logic v, input logic st, input logic sg,
                      input logic [1:0] md, input logic [31:0] w,
                      input logic [31:0] a, input string tag);
    int side;
    logic chg;
    @(negedge clk);
    checks++;
    if (out_valid !== ev2 || acc_flat !== ea2) begin
      errors++;
      $display("FAIL %s: out_valid=%0b acc=%h expected out_valid=%0b acc=%h",
               tg2, out_valid, acc_flat, ev2, ea2);
    end
    ev2 = ev1; ea2 = ea1; tg2 = tg1;
    in_valid = v; acc_start = st; is_signed = sg; mode = md;
    w_vec = w; a_vec = a;
    side = side_for(md);
    chg = (side != prev_side);
    if (chg) for (int g = 0; g < NU; g++) macc[g] = '0;
    if (v) begin
      for (int g = 0; g < NU; g++) begin
        if (st || chg) macc[g] = lane_prod(g, side, sg, w, a);
        else           macc[g] = macc[g] + lane_prod(g, side, sg, w, a);
      end
    end
    prev_side = side;
    ev1 = v;
    for (int g = 0; g < NU; g++) ea1[g*AW +: AW] = macc[g];
    tg1 = tag;
  endtask

  task automatic idle(input logic [1:0] md, input string tag);
    step(1'b0, 1'b0, 1'b0, md, 32'h0, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < NU; g++) macc[g] = '0;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 0; acc_start = 0; is_signed = 0; mode = 2'b00;
    w_vec = '0; a_vec = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state observed by the first checks
    idle(2'b00, "R1");
    idle(2'b00, "R1");
    // R2 R5: sixteen lanes of -2 x -2 signed, then unsigned add of 2 x 2
    step(1, 1, 1, 2'b00, 32'hAAAA_AAAA, 32'hAAAA_AAAA, "R2_R5");
    step(1, 0, 0, 2'b00, 32'hAAAA_AAAA, 32'hAAAA_AAAA, "R7");
    step(1, 0, 1, 2'b00, 32'h1B1B_E4E4, 32'h7777_9999, "R2");
    idle(2'b00, "R2");
    // R8: width change while idle clears all lanes
    idle(2'b01, "R8");
    // R3 R10: 4-bit lanes with junk above bit 15
    step(1, 0, 1, 2'b01, 32'hBEEF_8F7A, 32'hCAFE_8F96, "R3_R10");
    step(1, 0, 0, 2'b01, 32'h1234_FFFF, 32'h5678_FFFF, "R7");
    // R4 R5: -128 x -128 and 255 x 255; mode 11 alias
    step(1, 1, 1, 2'b10, 32'h0000_0080, 32'h0000_0080, "R4_R5");
    step(1, 1, 0, 2'b10, 32'hDEAD_BEFF, 32'h1234_56FF, "R4_R10");
    step(1, 0, 1, 2'b11, 32'h0000_0081, 32'h0000_007F, "R4");
    // R9: seventeen 255 x 255 products wrap past 2^20
    step(1, 1, 0, 2'b11, 32'h0000_00FF, 32'h0000_00FF, "R9");
    for (int i = 0; i < 16; i++)
      step(1, 0, 0, 2'b10, 32'h0000_00FF, 32'h0000_00FF, "R9");
    // R8: valid input with width change loads, ignoring start=0
    step(1, 0, 0, 2'b00, 32'h5555_5555, 32'hFFFF_FFFF, "R8");
    step(1, 0, 1, 2'b01, 32'h0000_7777, 32'h0000_8888, "R8");
    // R6: gaps between valid inputs
    idle(2'b01, "R6");
    step(1, 0, 1, 2'b01, 32'h0000_1234, 32'h0000_4321, "R6");
    idle(2'b01, "R6");
    // random mix across all requirements
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] md;
      md = (($urandom % 8) == 0) ? 2'($urandom) : mode;
      step(($urandom % 4) != 0, ($urandom % 6) == 0, 1'($urandom), md,
           $urandom, $urandom, "R2_R3_R4_R7");
    end
    idle(mode, "R6");
    idle(mode, "R6");
    idle(mode, "R6");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule